// File: doc/BRIEF.md
# Inrush Window Fault Timer

This block times the inrush phase of one powered channel. When the channel is switched on, the block opens a window of a programmed number of millisecond ticks. It reads the length from a 2-bit select code and holds that length until the window closes. Once the last tick of the window arrives, the block looks at the inrush current-limit flag. If the flag is low, the window-expired output goes high and stays high while the channel remains on. Downstream overcurrent fault timers use that output as their enable. If the flag is still high, the block ends the window in a fault instead.

On a fault, the block issues a single-cycle power-off request and drops the channel-on status. It then starts a cool-down of fixed length, and no turn-on is accepted until that cool-down ends. When the cool-down ends in semi-automatic operation, the block pulses a detection-restart request, but only if class and detect are both enabled. A reset command aborts a running window or cool-down at any time and returns the block to idle.

Top module: `inrush_guard`

## Requirements
- R1: After reset, all five outputs are low: chan_on, win_done, fault_off, cool_busy and det_restart.
- R2: The turn_on strobe is accepted only in idle, and chan_on rises on the following cycle. With win_sel 00 the window is 60 ticks, with 01 it is 30, and with 10 it is 120. Ticks are counted from the cycle after acceptance.
- R3: The reserved select code 11 gives the 60-tick window.
- R4: The length is captured when turn_on is accepted. A change to win_sel while the window runs does not alter the window.
- R5: The inrush flag is checked on the final tick of the window. If the flag is high there, fault_off pulses high for exactly one cycle. In that same cycle chan_on and win_done are low and cool_busy is high.
- R6: cool_busy stays high for exactly 1000 ticks. A turn_on during this time is refused and chan_on stays low.
- R7: If the flag is low on the final tick, win_done rises together with the window end. win_done then stays high, with chan_on high, until a reset command. Turn_on strobes in this state have no effect.
- R8: At the end of a cool-down, det_restart pulses for one cycle only if semi_auto, class_en and det_en were all high on the last cool-down tick.
- R9: A reset_cmd strobe takes priority over every other input. On the next cycle the block is idle and all outputs are low.
- R10: The flag's value before the final tick does not matter. A flag that was high earlier but is low on the final tick gives no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| win_sel | input | 2 | Inrush window select code |
| turn_on | input | 1 | Channel turn-on strobe |
| inrush_lim | input | 1 | Channel is current-limited during inrush |
| semi_auto | input | 1 | Semi-automatic operating mode |
| class_en | input | 1 | Classification enable |
| det_en | input | 1 | Detection enable |
| reset_cmd | input | 1 | Reset command strobe, aborts window and cool-down |
| chan_on | output | 1 | Channel power enabled (running or expired window) |
| win_done | output | 1 | Window expired without fault, channel still on |
| fault_off | output | 1 | One-cycle power-off request on inrush fault |
| cool_busy | output | 1 | Cool-down in progress |
| det_restart | output | 1 | One-cycle detection restart request |

## Verification
Every output comes straight from a register. A strobe or tick sampled at one clock edge therefore shows its result on the outputs right after that same edge. The window end appears after the edge that carries the final tick, and the chan_on change after the edge that accepted the turn-on. The bench drives inputs and samples outputs on the falling edge, so each result is compared half a cycle after the edge that produced it. Its reference model steps on the same rising edge and counts ticks down from the window length, which gives the expected value for each falling-edge comparison. Directed runs count falling edges from the turn-on strobe to the rise of win_done, expecting the window length plus one.

// File: rtl/inrush_pkg.sv
package inrush_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ON, ST_COOL} inr_st_t;

  // window length in ticks for a select code; the reserved code falls back to the first
  function automatic int unsigned win_ticks(input logic [1:0] code,
                                            input int unsigned len_a,
                                            input int unsigned len_b,
                                            input int unsigned len_c);
    case (code)
      2'b01:   return len_b;
      2'b10:   return len_c;
      default: return len_a;
    endcase
  endfunction
endpackage

// File: rtl/inrush_len_latch.sv
module inrush_len_latch import inrush_pkg::*; #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned LEN_A = 60,
  parameter int unsigned LEN_B = 30,
  parameter int unsigned LEN_C = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] len_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= CNT_W'(LEN_A);
    else if (load) len_q <= CNT_W'(win_ticks(sel, LEN_A, LEN_B, LEN_C));
  end

  // R4: the captured length only moves when a turn-on is accepted
  a_r4_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(len_q));
endmodule

// File: rtl/inrush_tick_cnt.sv
module inrush_tick_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] count;

  assign hit = step && (({1'b0, count} + 1'b1) == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // R6: the running count never reaches the active limit
  a_r6_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    count < limit);
endmodule

// File: rtl/inrush_guard.sv
module inrush_guard import inrush_pkg::*; #(
  parameter int unsigned WIN_A_MS = 60,
  parameter int unsigned WIN_B_MS = 30,
  parameter int unsigned WIN_C_MS = 120,
  parameter int unsigned COOL_MS  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic [1:0] win_sel,
  input  logic       turn_on,
  input  logic       inrush_lim,
  input  logic       semi_auto,
  input  logic       class_en,
  input  logic       det_en,
  input  logic       reset_cmd,
  output logic       chan_on,
  output logic       win_done,
  output logic       fault_off,
  output logic       cool_busy,
  output logic       det_restart
);
  localparam int unsigned MAX_AB = (WIN_A_MS > WIN_B_MS) ? WIN_A_MS : WIN_B_MS;
  localparam int unsigned MAX_W  = (MAX_AB > WIN_C_MS) ? MAX_AB : WIN_C_MS;
  localparam int unsigned MAX_T  = (MAX_W > COOL_MS) ? MAX_W : COOL_MS;
  localparam int unsigned CNT_W  = $clog2(MAX_T + 1);

  inr_st_t          st_q, st_d;
  logic [CNT_W-1:0] len_q, limit;
  logic             hit, step, cnt_clr;
  logic             ev_accept, ev_win_end, ev_fault, ev_cool_end, ev_restart;
  logic             fault_q, det_q;

  // named events
  assign ev_accept   = !reset_cmd && (st_q == ST_IDLE) && turn_on;
  assign ev_win_end  = !reset_cmd && (st_q == ST_RUN) && hit;
  assign ev_fault    = ev_win_end && inrush_lim;
  assign ev_cool_end = !reset_cmd && (st_q == ST_COOL) && hit;
  assign ev_restart  = ev_cool_end && semi_auto && class_en && det_en;

  assign step    = tick_1ms && ((st_q == ST_RUN) || (st_q == ST_COOL));
  assign cnt_clr = reset_cmd || ev_accept || ev_win_end || ev_cool_end;
  assign limit   = (st_q == ST_COOL) ? CNT_W'(COOL_MS) : len_q;

  inrush_len_latch #(
    .CNT_W(CNT_W), .LEN_A(WIN_A_MS), .LEN_B(WIN_B_MS), .LEN_C(WIN_C_MS)
  ) u_len (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .sel(win_sel), .len_q(len_q)
  );

  inrush_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(step), .limit(limit), .hit(hit)
  );

  always_comb begin
    st_d = st_q;
    if (reset_cmd)        st_d = ST_IDLE;
    else if (ev_accept)   st_d = ST_RUN;
    else if (ev_fault)    st_d = ST_COOL;
    else if (ev_win_end)  st_d = ST_ON;
    else if (ev_cool_end) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= ev_fault;
      det_q   <= ev_restart;
    end
  end

  assign chan_on     = (st_q == ST_RUN) || (st_q == ST_ON);
  assign win_done    = (st_q == ST_ON);
  assign cool_busy   = (st_q == ST_COOL);
  assign fault_off   = fault_q;
  assign det_restart = det_q;

  // R5: a fault request coincides with power removed and cool-down running
  a_r5_fault_kills_power: assert property (@(posedge clk) disable iff (!rst_n)
    fault_off |-> (!chan_on && !win_done && cool_busy));
  // R5: the request is a single-cycle pulse
  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_off |=> !fault_off);
  // R6: turn-on is refused during cool-down
  a_r6_no_on_in_cool: assert property (@(posedge clk) disable iff (!rst_n)
    cool_busy |=> !chan_on);
  // R7: expired window implies the channel is on
  a_r7_done_implies_on: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> chan_on);
  // R7: only a reset command ends the expired state
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !reset_cmd) |=> win_done);
  // R8: restart only at cool-down exit with all enables set
  a_r8_restart_gated: assert property (@(posedge clk) disable iff (!rst_n)
    det_restart |-> (!cool_busy && $past(cool_busy) &&
                     $past(semi_auto) && $past(class_en) && $past(det_en)));
  // R9: reset command clears everything on the next cycle
  a_r9_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (!chan_on && !win_done && !fault_off && !cool_busy && !det_restart));
  // R2: power only comes up from idle on an accepted strobe
  a_r2_on_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_on) |-> $past(turn_on));
endmodule

// File: tb/sim_inrush_guard.sv
module sim_inrush_guard;
  localparam int CLK_PERIOD = 10;
  localparam int COOL_T = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1ms = 1'b0, turn_on = 1'b0, inrush_lim = 1'b0;
  logic semi_auto = 1'b0, class_en = 1'b0, det_en = 1'b0, reset_cmd = 1'b0;
  logic [1:0] win_sel = 2'b00;
  logic chan_on, win_done, fault_off, cool_busy, det_restart;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inrush_guard u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .win_sel(win_sel),
    .turn_on(turn_on), .inrush_lim(inrush_lim), .semi_auto(semi_auto),
    .class_en(class_en), .det_en(det_en), .reset_cmd(reset_cmd),
    .chan_on(chan_on), .win_done(win_done), .fault_off(fault_off),
    .cool_busy(cool_busy), .det_restart(det_restart)
  );

  function automatic int sel_len(input logic [1:0] s);
    if (s == 2'b01) return 30;
    if (s == 2'b10) return 120;
    return 60; // 00 and reserved 11
  endfunction

  // reference model: 0 idle, 1 running, 2 expired, 3 cooling; counts remaining ticks down
  int m_ph = 0, m_left = 0;
  bit m_fault = 0, m_det = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_left <= 0; m_fault <= 0; m_det <= 0;
    end else begin
      m_fault <= 0; m_det <= 0;
      if (reset_cmd) m_ph <= 0;
      else if (m_ph == 0) begin
        if (turn_on) begin m_ph <= 1; m_left <= sel_len(win_sel); end
      end else if (m_ph == 1) begin
        if (tick_1ms) begin
          if (m_left == 1) begin
            if (inrush_lim) begin m_ph <= 3; m_left <= COOL_T; m_fault <= 1; end
            else m_ph <= 2;
          end else m_left <= m_left - 1;
        end
      end else if (m_ph == 3) begin
        if (tick_1ms) begin
          if (m_left == 1) begin m_ph <= 0; m_det <= semi_auto && class_en && det_en; end
          else m_left <= m_left - 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // continuous comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "chan_on", chan_on, (m_ph == 1 || m_ph == 2));
      chk("R7", "win_done", win_done, (m_ph == 2));
      chk("R5", "fault_off", fault_off, m_fault);
      chk("R6", "cool_busy", cool_busy, (m_ph == 3));
      chk("R8", "det_restart", det_restart, m_det);
    end
  end

  task automatic do_reset_cmd();
    @(negedge clk); reset_cmd = 1; turn_on = 1;
    @(negedge clk); reset_cmd = 0; turn_on = 0;
    chk("R9", "idle after reset_cmd", {chan_on, win_done, cool_busy}, 0);
  endtask

  // strobe turn_on with ticks every cycle, count falling edges until win_done
  task automatic measure(input logic [1:0] s, input logic [1:0] late_s,
                         input string req, input int exp_len);
    int n;
    @(negedge clk); win_sel = s; tick_1ms = 1; turn_on = 1; inrush_lim = 0;
    @(negedge clk); turn_on = 0;
    n = 1;
    while (!win_done && n < 400) begin
      if (n == 5) win_sel = late_s;
      if (n == 10) turn_on = 1;   // ignored while running
      if (n == 11) turn_on = 0;
      @(negedge clk); n++;
    end
    chk(req, "window edges", n, exp_len + 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {chan_on, win_done, fault_off, cool_busy, det_restart}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "outputs after reset", {chan_on, win_done, fault_off, cool_busy, det_restart}, 0);

    measure(2'b00, 2'b00, "R2", 60);
    // R7: turn_on while expired has no effect, win_done holds
    turn_on = 1; @(negedge clk); turn_on = 0; repeat (20) @(negedge clk);
    chk("R7", "win_done held", win_done, 1);
    do_reset_cmd();
    measure(2'b01, 2'b01, "R2", 30);
    do_reset_cmd();
    measure(2'b10, 2'b10, "R2", 120);
    do_reset_cmd();
    measure(2'b11, 2'b11, "R3", 60);
    do_reset_cmd();
    measure(2'b01, 2'b10, "R4", 30);
    do_reset_cmd();

    // R10: flag high early, low at the last tick -> no fault
    win_sel = 2'b01; turn_on = 1; inrush_lim = 1;
    @(negedge clk); turn_on = 0;
    repeat (28) @(negedge clk);
    inrush_lim = 0;
    repeat (3) @(negedge clk);
    chk("R10", "no fault when flag drops", {win_done, cool_busy}, 2'b10);
    do_reset_cmd();

    // R5/R6/R8: fault, refused turn-on, restart with all enables
    semi_auto = 1; class_en = 1; det_en = 1;
    win_sel = 2'b01; turn_on = 1; inrush_lim = 1;
    @(negedge clk); turn_on = 0;
    repeat (29) @(negedge clk);
    @(negedge clk);
    chk("R5", "fault pulse", {fault_off, chan_on, cool_busy}, 3'b101);
    @(negedge clk);
    chk("R5", "pulse ends", fault_off, 0);
    turn_on = 1; @(negedge clk); turn_on = 0;
    chk("R6", "turn_on refused", chan_on, 0);
    repeat (COOL_T - 3) @(negedge clk);
    chk("R6", "still cooling", cool_busy, 1);
    @(negedge clk);
    chk("R8", "restart pulse", {cool_busy, det_restart}, 2'b01);

    // R8: class disabled gives no restart
    class_en = 0; win_sel = 2'b01; turn_on = 1; inrush_lim = 1;
    @(negedge clk); turn_on = 0;
    repeat (30 + COOL_T) @(negedge clk);
    chk("R8", "no restart without class_en", {cool_busy, det_restart}, 0);

    // R9: reset command aborts a cool-down
    turn_on = 1; @(negedge clk); turn_on = 0;
    repeat (40) @(negedge clk);
    chk("R9", "cooling before abort", cool_busy, 1);
    do_reset_cmd();
    inrush_lim = 0;

    // constrained random phase
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      tick_1ms   = ($urandom_range(0, 1) == 0);
      turn_on    = ($urandom_range(0, 40) == 0);
      reset_cmd  = ($urandom_range(0, 3000) == 0);
      if ($urandom_range(0, 50) == 0) inrush_lim = ~inrush_lim;
      if ($urandom_range(0, 200) == 0) win_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 500) == 0) begin
        semi_auto = 1'($urandom_range(0, 1));
        class_en  = 1'($urandom_range(0, 1));
        det_en    = 1'($urandom_range(0, 1));
      end
    end
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule